// File: doc/BRIEF.md
# Receive Frame Admission Filter

This block sits on the receive path of an Ethernet MAC and decides, frame by frame, whether a frame is passed on or thrown away. Frame bytes arrive as a valid/ready byte stream with first and last markers. The block first looks at the destination address and sorts it into broadcast, multicast or unicast. It then applies the filter control bits and a single station-address comparison. Frames that pass the filter are then checked against two length limits: a programmable maximum frame size and the fixed standard maximum of 1518 bytes. Both limits count four extra bytes for the frame check sequence.

The stream never back-pressures: `in_ready` is high whenever the block is out of reset, and a beat is taken on every clock edge where `in_valid` and `in_ready` are both high. The verdict is issued as a one-cycle `dec_valid` pulse, together with the accept and long-frame flags and any drop event, in the cycle after the last byte is taken. A separate one-cycle pulse shows that the length/type field has arrived. The address-enable and maximum-size settings are held in two small registers written through a select/strobe port. The other controls are plain level inputs and are read on the last beat of each frame.

Top module: `rx_admit_filter`

## Requirements
- R1: `in_ready` is 1 whenever `rst_n` is 1. After the beat that carries `in_last`, `dec_valid` pulses for exactly one cycle, in the next cycle. `dec_accept`, `dec_long` and the drop events are valid only in that cycle.
- R2: `ev_hdr` pulses for one cycle, in the cycle after the 14th byte of a frame (byte index 13) is taken. This happens whatever the filter result is.
- R3: A frame of fewer than 14 bytes gives `dec_valid`=1 with `dec_accept`=0 and raises no event at all.
- R4: A broadcast destination is all six bytes equal to 0xFF. Such a frame passes the filter when `flt_ctrl[4]` (complement) is 1, or else when `flt_ctrl[2]` (accept broadcast) is 1.
- R5: A multicast destination has bit 0 of the first byte set and is not broadcast. Such a frame passes when `flt_ctrl[4]` is 1, or else when `flt_ctrl[1]` (accept multicast) is 1.
- R6: A unicast frame passes at once when `flt_ctrl[0]` (accept all unicast) is 1. Otherwise it matches when `flt_ctrl[3]` (compare enable) is 1, address-enable bit 0 is 1, and destination bytes 0..5 equal `sta_hi[31:24]`, `sta_hi[23:16]`, `sta_hi[15:8]`, `sta_hi[7:0]`, `sta_lo[31:24]`, `sta_lo[23:16]`. `sta_lo[15:0]` is ignored.
- R7: A write with `cfg_sel`=0 stores only bit 0 of `cfg_wdata` into the address-enable register. `en_rd[15:1]` always reads 0. The register resets to 0.
- R8: When `flt_ctrl[4]` is 1 and `flt_ctrl[0]` is 0, the unicast match result is inverted: a matching address is dropped and a non-matching address passes.
- R9: The maximum-size register is written with `cfg_sel`=1 and resets to 0x800. A frame that passes the filter with length+4 greater than this value is dropped with `ev_oversize`.
- R10: A frame that passes both earlier checks, with length+4 greater than 1518, is dropped with `ev_toolong` when `long_ok` is 0. When `long_ok` is 1 it is accepted with `dec_long`=1.
- R11: A frame rejected by the filter raises no size event. The oversize check takes priority over the too-long check, so at most one drop event is raised per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Beat accepted (high out of reset) |
| in_data | input | 8 | Frame byte |
| in_first | input | 1 | First byte of a frame |
| in_last | input | 1 | Last byte of a frame |
| flt_ctrl | input | 5 | [0] all unicast, [1] multicast, [2] broadcast, [3] compare enable, [4] complement |
| sta_hi | input | 32 | Station address bytes 0..3, byte 0 in the top byte |
| sta_lo | input | 32 | Station address bytes 4..5 in bits 31:16 |
| long_ok | input | 1 | Accept frames over the standard maximum |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 address-enable, 1 maximum size |
| cfg_wdata | input | 16 | Register write data |
| en_rd | output | 16 | Address-enable register readback |
| mfs_rd | output | 16 | Maximum-size register readback |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_long | output | 1 | Accepted frame is over the standard maximum |
| ev_hdr | output | 1 | Length/type field received |
| ev_oversize | output | 1 | Dropped: over programmed maximum |
| ev_toolong | output | 1 | Dropped: over standard maximum |

## Verification
The assertions assume that every frame opens with a beat that has `in_first` set and closes with exactly one beat that has `in_last` set. They also assume that `long_ok`, `flt_ctrl` and the station address do not change between the last beat and the verdict. The bench keeps to these rules: it drives whole frames through one task, sets the first and last markers from the frame length, and changes configuration only while the stream is idle. Beats are sent back to back with no gaps. Frame lengths are chosen around each limit (13/14 bytes, the programmed maximum and 1518) so that each boundary is met from both sides.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int FC_UCAST_ALL = 0;
  localparam int FC_MCAST     = 1;
  localparam int FC_BCAST     = 2;
  localparam int FC_CMP_EN    = 3;
  localparam int FC_COMPL     = 4;
  localparam int FC_W         = 5;

  localparam int ADDR_BYTES   = 6;
  localparam int HDR_BYTES    = 14;
  localparam int FCS_BYTES    = 4;

  typedef enum logic [1:0] {DST_UCAST, DST_MCAST, DST_BCAST} dst_kind_e;

  function automatic logic [7:0] station_byte(input logic [31:0] hi,
                                               input logic [15:0] lo_top,
                                               input int idx);
    logic [47:0] packed_addr;
    packed_addr = {hi, lo_top};
    return packed_addr[47 - 8*idx -: 8];
  endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs #(
  parameter int RD_W      = 16,
  parameter int MFS_RESET = 16'h0800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            sel,
  input  logic [RD_W-1:0] wdata,
  output logic            en0,
  output logic [RD_W-1:0] mfs,
  output logic [RD_W-1:0] en_rd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en0 <= 1'b0;
      mfs <= RD_W'(MFS_RESET);
    end else if (wr) begin
      if (sel) mfs <= wdata;
      else     en0 <= wdata[0];
    end
  end

  assign en_rd = {{(RD_W-1){1'b0}}, en0};
endmodule

// File: rtl/rxf_dest_track.sv
module rxf_dest_track
  import rxf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             first,
  input  logic [7:0]       data,
  input  logic [31:0]      sta_hi,
  input  logic [15:0]      sta_lo_top,
  output logic [CNT_W-1:0] cnt_now,
  output dst_kind_e        kind,
  output logic             addr_match,
  output logic             hdr_now
);
  logic [CNT_W-1:0] cnt_q;
  logic             ones_q, grp_q, match_q;
  logic [7:0]       exp_byte [ADDR_BYTES];
  logic             byte_eq;

  assign cnt_now = first ? '0 : cnt_q;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta
    assign exp_byte[g] = station_byte(sta_hi, sta_lo_top, g);
  end

  always_comb begin
    byte_eq = 1'b0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt_now == CNT_W'(i)) byte_eq = (data == exp_byte[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ones_q  <= 1'b0;
      grp_q   <= 1'b0;
      match_q <= 1'b0;
    end else if (beat) begin
      if (cnt_now != '1) cnt_q <= cnt_now + 1'b1;
      if (cnt_now == '0) begin
        ones_q  <= (data == 8'hFF);
        grp_q   <= data[0];
        match_q <= byte_eq;
      end else if (cnt_now < CNT_W'(ADDR_BYTES)) begin
        ones_q  <= ones_q & (data == 8'hFF);
        match_q <= match_q & byte_eq;
      end
    end
  end

  assign hdr_now    = beat && (cnt_now == CNT_W'(HDR_BYTES - 1));
  assign addr_match = match_q;
  assign kind       = ones_q ? DST_BCAST : (grp_q ? DST_MCAST : DST_UCAST);
endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict
  import rxf_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MFS_W     = 16,
  parameter int STD_LIMIT = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  input  logic [CNT_W-1:0] cnt_now,
  input  dst_kind_e        kind,
  input  logic             addr_match,
  input  logic             hdr_now,
  input  logic [FC_W-1:0]  ctrl,
  input  logic             en0,
  input  logic [MFS_W-1:0] mfs,
  input  logic             long_ok,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_long,
  output logic             ev_hdr,
  output logic             ev_oversize,
  output logic             ev_toolong
);
  localparam int LW = (CNT_W > MFS_W ? CNT_W : MFS_W) + 2;

  logic [LW-1:0] len_fcs;
  logic          is_short, pass, uc_match, uc_pass, over_max, over_std;
  logic          acc_d, long_d, evo_d, evl_d;

  assign len_fcs  = LW'(cnt_now) + LW'(1 + FCS_BYTES);
  assign is_short = (cnt_now < CNT_W'(HDR_BYTES - 1));
  assign over_max = len_fcs > LW'(mfs);
  assign over_std = len_fcs > LW'(STD_LIMIT);
  assign uc_match = ctrl[FC_CMP_EN] && en0 && addr_match;
  assign uc_pass  = ctrl[FC_UCAST_ALL] || (ctrl[FC_COMPL] ? !uc_match : uc_match);

  always_comb begin
    unique case (kind)
      DST_BCAST: pass = ctrl[FC_COMPL] || ctrl[FC_BCAST];
      DST_MCAST: pass = ctrl[FC_COMPL] || ctrl[FC_MCAST];
      default:   pass = uc_pass;
    endcase
    acc_d  = 1'b0;
    long_d = 1'b0;
    evo_d  = 1'b0;
    evl_d  = 1'b0;
    if (!is_short && pass) begin
      if (over_max)                 evo_d = 1'b1;
      else if (over_std && !long_ok) evl_d = 1'b1;
      else begin
        acc_d  = 1'b1;
        long_d = over_std;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_accept  <= 1'b0;
      dec_long    <= 1'b0;
      ev_hdr      <= 1'b0;
      ev_oversize <= 1'b0;
      ev_toolong  <= 1'b0;
    end else begin
      dec_valid   <= beat && last;
      dec_accept  <= beat && last && acc_d;
      dec_long    <= beat && last && long_d;
      ev_oversize <= beat && last && evo_d;
      ev_toolong  <= beat && last && evl_d;
      ev_hdr      <= hdr_now;
    end
  end
endmodule

// File: rtl/rx_admit_filter.sv
module rx_admit_filter
  import rxf_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MFS_W     = 16,
  parameter int MFS_RESET = 16'h0800,
  parameter int STD_LIMIT = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [4:0]       flt_ctrl,
  input  logic [31:0]      sta_hi,
  input  logic [31:0]      sta_lo,
  input  logic             long_ok,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [MFS_W-1:0] cfg_wdata,
  output logic [MFS_W-1:0] en_rd,
  output logic [MFS_W-1:0] mfs_rd,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_long,
  output logic             ev_hdr,
  output logic             ev_oversize,
  output logic             ev_toolong
);
  logic             beat, en0, addr_match, hdr_now;
  logic [CNT_W-1:0] cnt_now;
  dst_kind_e        kind;
  logic             unused_lo;

  assign in_ready  = rst_n;
  assign beat      = in_valid && in_ready;
  assign unused_lo = ^sta_lo[15:0];

  rxf_cfg_regs #(.RD_W(MFS_W), .MFS_RESET(MFS_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .en0(en0), .mfs(mfs_rd), .en_rd(en_rd)
  );

  rxf_dest_track #(.CNT_W(CNT_W)) u_dest (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(in_first), .data(in_data),
    .sta_hi(sta_hi), .sta_lo_top(sta_lo[31:16]), .cnt_now(cnt_now),
    .kind(kind), .addr_match(addr_match), .hdr_now(hdr_now)
  );

  rxf_verdict #(.CNT_W(CNT_W), .MFS_W(MFS_W), .STD_LIMIT(STD_LIMIT)) u_verdict (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(in_last), .cnt_now(cnt_now),
    .kind(kind), .addr_match(addr_match), .hdr_now(hdr_now), .ctrl(flt_ctrl),
    .en0(en0), .mfs(mfs_rd), .long_ok(long_ok), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_long(dec_long), .ev_hdr(ev_hdr),
    .ev_oversize(ev_oversize), .ev_toolong(ev_toolong)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int MFS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             long_ok,
  input logic [MFS_W-1:0] en_rd,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic             dec_long,
  input logic             ev_hdr,
  input logic             ev_oversize,
  input logic             ev_toolong
);
  assert_verdict_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_ready && in_last));

  assert_hdr_after_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr |-> $past(in_valid && in_ready));

  assert_en_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_rd[MFS_W-1:1] == '0);

  assert_drop_is_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_oversize || ev_toolong) |-> (dec_valid && !dec_accept));

  assert_long_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_long |-> (dec_accept && $past(long_ok)));

  assert_single_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_oversize, ev_toolong}) <= 1);
endmodule

bind rx_admit_filter rxf_checker #(.MFS_W(MFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .long_ok(long_ok), .en_rd(en_rd), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .dec_long(dec_long), .ev_hdr(ev_hdr),
  .ev_oversize(ev_oversize), .ev_toolong(ev_toolong)
);

// File: tb/rx_admit_filter_tb.sv
module rx_admit_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic [4:0]  flt_ctrl = '0;
  logic [31:0] sta_hi = 32'h02112233;
  logic [31:0] sta_lo = 32'h4455ABCD;
  logic        long_ok = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] en_rd, mfs_rd;
  logic        dec_valid, dec_accept, dec_long, ev_hdr, ev_oversize, ev_toolong;

  int checks = 0, failures = 0;
  logic [7:0] fb [2048];
  int hdr_at;
  int hdr_count;
  logic [47:0] STA = 48'h0211_2233_4455;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_admit_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .flt_ctrl(flt_ctrl), .sta_hi(sta_hi), .sta_lo(sta_lo), .long_ok(long_ok),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .en_rd(en_rd),
    .mfs_rd(mfs_rd), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_long(dec_long), .ev_hdr(ev_hdr), .ev_oversize(ev_oversize),
    .ev_toolong(ev_toolong)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [47:0] dst, input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 6; i++) fb[i] = dst[47 - 8*i -: 8];
    for (int i = 6; i < 12 && i < len; i++) fb[i] = 8'h10 + 8'(i);
  endtask

  // Called at a negedge. Returns at the negedge after the verdict edge.
  task automatic send(input int len);
    hdr_at = -1;
    hdr_count = 0;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = fb[i];
      in_first = (i == 0);
      in_last  = (i == len - 1);
      @(posedge clk);
      @(negedge clk);
      if (ev_hdr) begin
        hdr_at = i;
        hdr_count++;
      end
    end
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic expect_dec(input string req, input bit acc, input bit lng,
                            input bit evo, input bit evl);
    chk(dec_valid == 1'b1, req, "dec_valid", dec_valid, 1);
    chk(dec_accept == acc, req, "dec_accept", dec_accept, acc);
    chk(dec_long == lng, req, "dec_long", dec_long, lng);
    chk(ev_oversize == evo, req, "ev_oversize", ev_oversize, evo);
    chk(ev_toolong == evl, req, "ev_toolong", ev_toolong, evl);
  endtask

  task automatic write_reg(input bit sel, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk(in_ready == 1'b0, "R1", "ready in reset", in_ready, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    chk(dec_valid == 1'b0, "R1", "dec_valid idle", dec_valid, 0);
    chk(mfs_rd == 16'h0800, "R9", "max size reset", mfs_rd, 16'h0800);
    chk(en_rd == 16'h0000, "R7", "enable reset", en_rd, 0);
  endtask

  task automatic t_enable_reg;
    write_reg(1'b0, 16'hFFFF);
    chk(en_rd == 16'h0001, "R7", "enable readback", en_rd, 1);
    write_reg(1'b0, 16'hFFFE);
    chk(en_rd == 16'h0000, "R7", "enable cleared", en_rd, 0);
    write_reg(1'b0, 16'h0001);
  endtask

  task automatic t_broadcast;
    flt_ctrl = 5'b00000;
    build(48'hFFFF_FFFF_FFFF, 60); send(60);
    expect_dec("R4", 0, 0, 0, 0);
    chk(hdr_at == 13 && hdr_count == 1, "R2", "hdr on dropped frame", hdr_at, 13);
    @(negedge clk);
    chk(dec_valid == 1'b0, "R1", "verdict one cycle", dec_valid, 0);
    flt_ctrl = 5'b00100;
    send(60); expect_dec("R4", 1, 0, 0, 0);
    flt_ctrl = 5'b10000;
    send(60); expect_dec("R4", 1, 0, 0, 0);
  endtask

  task automatic t_multicast;
    flt_ctrl = 5'b00100;
    build(48'h0100_5E00_0001, 64); send(64);
    expect_dec("R5", 0, 0, 0, 0);
    flt_ctrl = 5'b00010;
    send(64); expect_dec("R5", 1, 0, 0, 0);
    flt_ctrl = 5'b10000;
    send(64); expect_dec("R5", 1, 0, 0, 0);
  endtask

  task automatic t_unicast;
    flt_ctrl = 5'b01000;
    build(STA, 60); send(60);
    expect_dec("R6", 1, 0, 0, 0);
    build(STA ^ 48'h1, 60); send(60);
    expect_dec("R6", 0, 0, 0, 0);
    build(STA ^ 48'h0100_0000_0000, 60); send(60);
    expect_dec("R6", 0, 0, 0, 0);
    sta_lo = 32'h4455_0000;
    build(STA, 60); send(60);
    expect_dec("R6", 1, 0, 0, 0);
    flt_ctrl = 5'b00000;
    send(60); expect_dec("R6", 0, 0, 0, 0);
    write_reg(1'b0, 16'h0000);
    flt_ctrl = 5'b01000;
    send(60); expect_dec("R6", 0, 0, 0, 0);
    flt_ctrl = 5'b00001;
    build(48'h0A0B_0C0D_0E0F, 60); send(60);
    expect_dec("R6", 1, 0, 0, 0);
    write_reg(1'b0, 16'h0001);
  endtask

  task automatic t_complement;
    flt_ctrl = 5'b11000;
    build(STA, 60); send(60);
    expect_dec("R8", 0, 0, 0, 0);
    build(48'h0A0B_0C0D_0E0F, 60); send(60);
    expect_dec("R8", 1, 0, 0, 0);
    flt_ctrl = 5'b11001;
    build(STA, 60); send(60);
    expect_dec("R8", 1, 0, 0, 0);
  endtask

  task automatic t_short;
    flt_ctrl = 5'b00100;
    build(48'hFFFF_FFFF_FFFF, 13); send(13);
    expect_dec("R3", 0, 0, 0, 0);
    chk(hdr_count == 0, "R3", "no hdr on short", hdr_count, 0);
    build(48'hFFFF_FFFF_FFFF, 14); send(14);
    expect_dec("R3", 1, 0, 0, 0);
    chk(hdr_at == 13, "R2", "hdr index at 14 bytes", hdr_at, 13);
  endtask

  task automatic t_oversize;
    flt_ctrl = 5'b00100;
    write_reg(1'b1, 16'd64);
    chk(mfs_rd == 16'd64, "R9", "max size write", mfs_rd, 64);
    build(48'hFFFF_FFFF_FFFF, 60); send(60);
    expect_dec("R9", 1, 0, 0, 0);
    build(48'hFFFF_FFFF_FFFF, 61); send(61);
    expect_dec("R9", 0, 0, 1, 0);
    flt_ctrl = 5'b00000;
    send(61); expect_dec("R11", 0, 0, 0, 0);
    flt_ctrl = 5'b00100;
    write_reg(1'b1, 16'd1500);
    build(48'hFFFF_FFFF_FFFF, 1515); send(1515);
    expect_dec("R11", 0, 0, 1, 0);
    write_reg(1'b1, 16'h0800);
  endtask

  task automatic t_toolong;
    flt_ctrl = 5'b00100;
    long_ok = 1'b0;
    build(48'hFFFF_FFFF_FFFF, 1514); send(1514);
    expect_dec("R10", 1, 0, 0, 0);
    build(48'hFFFF_FFFF_FFFF, 1515); send(1515);
    expect_dec("R10", 0, 0, 0, 1);
    long_ok = 1'b1;
    send(1515); expect_dec("R10", 1, 1, 0, 0);
    long_ok = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_enable_reg();
    t_broadcast();
    t_multicast();
    t_unicast();
    t_complement();
    t_short();
    t_oversize();
    t_toolong();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule